// File: doc/BRIEF.md
# Serial Byte Transmitter

This block turns parallel bytes into an asynchronous serial frame on a single line. A byte is offered with a valid/ready handshake. When both signals are high on a clock edge, the byte is copied into an internal holding register. A producer may therefore pulse valid for a single cycle and change its data right after. The frame is one low start bit, eight data bits sent least significant first, and one high stop bit. Each bit lasts the same number of clock cycles, which is the clock frequency parameter divided by the baud rate parameter.

A four-state controller sequences the frame through idle, start, data and stop. It works alongside two counters. One counts clock cycles inside a bit period. The other counts data bits already sent. Both counters return to zero at every edge where the controller changes state, so each state measures its own time from zero. The line output and the ready output are registers whose next values are decoded from the controller's next state. Ready is high only while the controller is idle.

Top module: `serial_byte_sender`

## Requirements
- R1: A synchronous active-high reset puts the block in idle, with the line at 1 and ready at 1. This holds even when reset arrives in the middle of a frame.
- R2: A byte is accepted on a rising edge where in_valid and in_ready are both 1. From that edge on, in_ready reads 0.
- R3: The start bit is 0 on tx_line for exactly CYCLES_PER_BIT clock cycles, beginning at the accepting edge.
- R4: The eight data bits follow the start bit, bit 0 first, each for exactly CYCLES_PER_BIT cycles. A data bit of value 1 drives tx_line to 1.
- R5: After the last data bit, tx_line is 1 for one stop period of CYCLES_PER_BIT cycles. At the next edge in_ready returns to 1, which is 10 × CYCLES_PER_BIT cycles after the accepting edge.
- R6: A single-cycle valid pulse is enough. Changing in_byte after the accepting edge has no effect on the frame being sent.
- R7: in_valid held high while in_ready is 0 is ignored. The current frame is unchanged, and no further frame starts once the line is idle and in_valid is low.
- R8: If in_valid is high in the first idle cycle after a frame, a new frame is accepted at the next edge. The gap between frames is a single idle cycle.
- R9: In idle, tx_line stays at 1.
- R10: The bit-period counter and the data-bit counter are both zero in the first cycle after any state change. As a result, every start, data and stop period has exactly the nominal length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte offered |
| in_byte | input | 8 | Byte to transmit |
| in_ready | output | 1 | Block idle, byte will be taken |
| tx_line | output | 1 | Serial output, 1 when idle |

## Verification
The bench builds the block with a 50 MHz clock parameter and a 5 MHz baud parameter, which gives ten cycles per bit. At that setting a whole frame takes a hundred cycles, so every data pattern, back-to-back frames, busy-time valid and a mid-frame reset fit in a short run. Ten is not a power of two, so the bit-period counter has to wrap at a value below its natural range. An off-by-one in the per-state clearing would stretch or shorten a bit period by one cycle, and the per-bit sampling at that resolution would catch it.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } tx_state_e;

    typedef struct packed {
        tx_state_e state;
        logic      line;
        logic      ready;
    } ctrl_regs_t;

endpackage

// File: rtl/sbs_baud_timer.sv
// Counts clock cycles inside one bit period; wraps at the period end and
// is forced to zero whenever the controller changes state.
module sbs_baud_timer #(
    parameter int CYCLES = 10,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    output logic             period_done,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        if (clear || count_q == LAST) begin
            count_d = '0;
        end else begin
            count_d = count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign period_done = (count_q == LAST);
    assign count       = count_q;

endmodule

// File: rtl/sbs_bit_counter.sv
// Counts finished data bits; advances only on period ends.
module sbs_bit_counter #(
    parameter int BITS  = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic             all_done,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (clear) begin
            count_d = '0;
        end else if (advance) begin
            count_d = (count_q == LAST) ? '0 : count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign all_done = advance && (count_q == LAST);
    assign count    = count_q;

endmodule

// File: rtl/sbs_shift_buf.sv
// Holding register: loaded as {byte, start slot}, shifted right on every
// period end regardless of state, filling with ones. Load has priority.
module sbs_shift_buf #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_data,
    input  logic                 shift,
    output logic                 next_lsb
);

    localparam int BUF_W = DATA_BITS + 1;

    logic [BUF_W-1:0] buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (load) begin
            buf_d = {load_data, 1'b0};
        end else if (shift) begin
            buf_d = {1'b1, buf_q[BUF_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '1;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign next_lsb = buf_d[0];

endmodule

// File: rtl/serial_byte_sender.sv
module serial_byte_sender #(
    parameter int CLK_HZ    = 50_000_000,
    parameter int BAUD_HZ   = 5_000_000,
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [DATA_BITS-1:0] in_byte,
    output logic                 in_ready,
    output logic                 tx_line
);
    import sbs_pkg::*;

    localparam int CYCLES_PER_BIT = CLK_HZ / BAUD_HZ;
    localparam int BAUD_W = (CYCLES_PER_BIT > 1) ? $clog2(CYCLES_PER_BIT) : 1;
    localparam int BIT_W  = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    ctrl_regs_t ctrl_d, ctrl_q;

    logic              accept;
    logic              state_change;
    logic              period_done;
    logic              data_done;
    logic              buf_lsb_next;
    logic [BAUD_W-1:0] baud_count;
    logic [BIT_W-1:0]  bit_count;
    tx_state_e         state_now;

    assign accept       = in_valid && ctrl_q.ready;
    assign state_change = (ctrl_d.state != ctrl_q.state);
    assign state_now    = ctrl_q.state;

    sbs_baud_timer #(
        .CYCLES (CYCLES_PER_BIT),
        .CNT_W  (BAUD_W)
    ) u_timer (
        .clk         (clk),
        .rst         (rst),
        .clear       (state_change),
        .period_done (period_done),
        .count       (baud_count)
    );

    sbs_bit_counter #(
        .BITS  (DATA_BITS),
        .CNT_W (BIT_W)
    ) u_bits (
        .clk      (clk),
        .rst      (rst),
        .clear    (state_change),
        .advance  (period_done),
        .all_done (data_done),
        .count    (bit_count)
    );

    sbs_shift_buf #(
        .DATA_BITS (DATA_BITS)
    ) u_buf (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_data (in_byte),
        .shift     (period_done),
        .next_lsb  (buf_lsb_next)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        // next state: hold by default, every state has its exit
        case (ctrl_q.state)
            ST_IDLE:  if (accept)      ctrl_d.state = ST_START;
            ST_START: if (period_done) ctrl_d.state = ST_DATA;
            ST_DATA:  if (data_done)   ctrl_d.state = ST_STOP;
            ST_STOP:  if (period_done) ctrl_d.state = ST_IDLE;
            default:                   ctrl_d.state = ST_IDLE;
        endcase
        // outputs decoded from the state being entered, so they line up
        // with the registered state
        case (ctrl_d.state)
            ST_START: ctrl_d.line = 1'b0;
            ST_DATA:  ctrl_d.line = buf_lsb_next;
            default:  ctrl_d.line = 1'b1;
        endcase
        ctrl_d.ready = (ctrl_d.state == ST_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.state <= ST_IDLE;
            ctrl_q.line  <= 1'b1;
            ctrl_q.ready <= 1'b1;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign in_ready = ctrl_q.ready;
    assign tx_line  = ctrl_q.line;

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int CYCLES = 10,
    parameter int BAUD_W = 4,
    parameter int BIT_W  = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic               tx_line,
    input sbs_pkg::tx_state_e state_i,
    input logic [BAUD_W-1:0]  baud_cnt_i,
    input logic [BIT_W-1:0]   bit_cnt_i
);
    import sbs_pkg::*;

    p_ready_only_idle_r2: assert property (@(posedge clk) disable iff (rst)
        in_ready == (state_i == ST_IDLE));

    p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (!in_ready && state_i == ST_START));

    p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_START) |-> !tx_line);

    p_baud_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        baud_cnt_i < BAUD_W'(CYCLES));

    p_stop_high_r5: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_STOP) |-> tx_line);

    p_busy_no_accept_r7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready && state_i != ST_STOP) |=> (state_i != ST_IDLE && state_i != ST_START) || $past(state_i) == ST_START);

    p_idle_high_r9: assert property (@(posedge clk) disable iff (rst)
        (state_i == ST_IDLE) |-> tx_line);

    p_counters_cleared_r10: assert property (@(posedge clk) disable iff (rst)
        (state_i != $past(state_i)) |-> (baud_cnt_i == '0 && bit_cnt_i == '0));

endmodule

bind serial_byte_sender sbs_checker #(
    .CYCLES (CYCLES_PER_BIT),
    .BAUD_W (BAUD_W),
    .BIT_W  (BIT_W)
) u_sbs_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .tx_line    (tx_line),
    .state_i    (state_now),
    .baud_cnt_i (baud_count),
    .bit_cnt_i  (bit_count)
);

// File: tb/serial_byte_sender_tb_top.sv
module serial_byte_sender_tb_top;

    localparam int CLK_HZ  = 50_000_000;
    localparam int BAUD_HZ = 5_000_000;
    localparam int CPB     = CLK_HZ / BAUD_HZ;
    localparam int FRAME   = 10 * CPB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready;
    logic       tx_line;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    serial_byte_sender #(
        .CLK_HZ    (CLK_HZ),
        .BAUD_HZ   (BAUD_HZ),
        .DATA_BITS (8)
    ) dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .in_ready (in_ready),
        .tx_line  (tx_line)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Called at a negedge with the block idle. Offers byte b; returns at the
    // negedge after the idle-entry edge (sample FRAME after acceptance).
    task automatic run_frame(input logic [7:0] b, input bit hold_valid);
        chk("R2", "ready before offer", int'(in_ready), 1);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        @(negedge clk);
        if (!hold_valid) in_valid = 1'b0;
        in_byte = ~b;                       // R6: later data must not matter
        chk("R2", "ready after accept", int'(in_ready), 0);
        for (int w = 0; w < 10; w++) begin
            int bad_line = 0;
            int bad_ready = 0;
            logic exp_bit;
            exp_bit = (w == 0) ? 1'b0 : (w == 9) ? 1'b1 : b[w-1];
            for (int c = 0; c < CPB; c++) begin
                if (tx_line !== exp_bit) bad_line++;
                if (in_ready !== 1'b0) bad_ready++;
                if (hold_valid && (w * CPB + c == FRAME - 1)) in_valid = 1'b0;
                @(negedge clk);
            end
            if (w == 0)
                chk("R3", "start bit low cycles wrong (R10 timing)", bad_line, 0);
            else if (w == 9)
                chk("R5", "stop bit high cycles wrong", bad_line, 0);
            else
                chk("R4", $sformatf("data bit %0d of %02h cycles wrong", w - 1, b), bad_line, 0);
            if (bad_ready != 0)
                chk(hold_valid ? "R7" : "R2", "ready high while busy", bad_ready, 0);
        end
        chk("R5", "ready back after frame", int'(in_ready), 1);
        chk("R5", "line high after frame", int'(tx_line), 1);
    endtask

    task automatic idle_check(input int n, input string req);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (tx_line !== 1'b1 || in_ready !== 1'b1) bad++;
            @(negedge clk);
        end
        chk(req, "idle line/ready not high", bad, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "line in reset", int'(tx_line), 1);
        chk("R1", "ready in reset", int'(in_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        idle_check(2 * CPB, "R9");
    endtask

    task automatic t_pulse;
        run_frame(8'hA5, 1'b0);   // R6 single-cycle valid
        idle_check(CPB, "R9");
    endtask

    task automatic t_patterns;
        run_frame(8'h00, 1'b0);   // R4
        run_frame(8'hFF, 1'b0);
        run_frame(8'h01, 1'b0);
        run_frame(8'h80, 1'b0);
        idle_check(CPB, "R9");
    endtask

    task automatic t_busy_valid;
        run_frame(8'h3C, 1'b1);   // R7 valid held while busy
        idle_check(2 * CPB, "R7");
    endtask

    task automatic t_back_to_back;
        run_frame(8'h5A, 1'b0);
        run_frame(8'hC3, 1'b0);   // R8 offered in first idle cycle
        idle_check(CPB, "R8");
    endtask

    task automatic t_reset_mid;
        in_valid = 1'b1;
        in_byte  = 8'h0F;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3 * CPB + 2) @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "line after mid-frame reset", int'(tx_line), 1);
        chk("R1", "ready after mid-frame reset", int'(in_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        run_frame(8'h96, 1'b0);   // R10 clean timing after restart
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_pulse();
        t_patterns();
        t_busy_valid();
        t_back_to_back();
        t_reset_mid();
        done_flag = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule